// File: doc/BRIEF.md
# Power-Up and Command Calibration Sequencer

This block decides when a self-calibration routine runs. It does not do the trimming. After reset it counts a settling delay of 2^S or 2^L clock cycles. A delay-select input chooses between the two. When the delay expires, it starts calibration. Software can also request a calibration through a control line. The request counts only as a qualified pulse: a run of low cycles followed by a run of high cycles. The block passes the control line through a synchronizer before it measures either run.

A power-down input has three effects:
- It freezes the delay counter.
- It blocks any start.
- It aborts a calibration that is in progress.

A busy output is high for the whole run. A run ends in one of two ways: the calibration engine raises a done input, or a modelled fixed duration elapses. A recalibration-request output tells the rest of the chip that the stored calibration no longer matches the operating conditions. It is set out of reset, after an abort, and on any change of the full-scale-range select. It clears when a run completes.

Top module: `cal_sequencer`

## Requirements
- R1: With the delay-select input low (0), power-up calibration starts automatically. `cal_busy_o` rises 2^DLY_EXP_SHORT + 1 clock cycles after reset is released, when `pwr_dn_i` stays low.
- R2: With the delay-select input high (1), the power-up delay is 2^DLY_EXP_LONG cycles. `cal_busy_o` rises 2^DLY_EXP_LONG + 1 cycles after reset release.
- R3: While `pwr_dn_i` is high (1), the power-up delay counter holds its value. The start of power-up calibration is pushed later by exactly the number of power-down cycles.
- R4: If `cal_cmd_i` is high when the power-up delay ends, the power-up calibration is withheld. A later qualified command still starts a calibration.
- R5: A qualified command starts calibration without waiting for `cal_cmd_i` to fall again. A qualified command is at least RUN_LEN consecutive low cycles of `cal_cmd_i`, then RUN_LEN consecutive high cycles. `cal_busy_o` rises RUN_LEN + 3 cycles after `cal_cmd_i` rises. A line that stays high starts only one calibration.
- R6: A low run shorter than RUN_LEN, or a high run shorter than RUN_LEN, starts no calibration.
- R7: `cal_busy_o` stays high for exactly CAL_CYCLES cycles, unless one of two things ends it earlier. If `cal_done_i` is high while busy, busy falls one cycle later. `cal_done_i` has no effect while the block is idle.
- R8: No calibration starts while `pwr_dn_i` is high. A command that qualifies during power-down is discarded and does not start a calibration later.
- R9: If `pwr_dn_i` is high while busy, busy falls one cycle later. `recal_req_o` is then high.
- R10: `recal_req_o` is high (1) out of reset and clears when a run completes. It is set one cycle after any change of `fsr_sel_i` and stays set until the next completed run.
- R11: A command that qualifies while a calibration runs is ignored. It neither extends the run nor starts another one afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_cmd_i | input | 1 | Asynchronous calibration command line (low run, then high run) |
| pwr_dn_i | input | 1 | Power-down: freezes the delay counter, blocks starts, aborts a run |
| dly_sel_i | input | 1 | Power-up delay select: 0 = 2^DLY_EXP_SHORT, 1 = 2^DLY_EXP_LONG |
| fsr_sel_i | input | 1 | Full-scale-range select; any change requests recalibration |
| cal_done_i | input | 1 | End-of-calibration indication from the calibration engine |
| cal_busy_o | output | 1 | High while a calibration runs |
| recal_req_o | output | 1 | Sticky flag: calibration is stale or missing |

## Verification
The bench runs the block with short delay exponents (4 and 6). It measures, to the cycle, the time from reset release or from a command edge until `cal_busy_o` rises, so any extra or missing pipeline stage shows up as a wrong count.

The command line is tried with several patterns:
- 9 low then 15 high.
- 20 low then 9 high.
- A full qualified pulse.
- A full qualified pulse during power-down.
- A full qualified pulse during a run.

These patterns separate a qualifier that counts runs from one that only watches edges. They also show whether a discarded command stays latched.

Power-down is applied during the delay and during a run. Together with the held-high reset case, this separates freezing the counter from restarting it, and aborting from withholding.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [1:0] {
      SRC_NONE    = 2'd0,
      SRC_POWERUP = 2'd1,
      SRC_COMMAND = 2'd2
   } cal_src_e;

endpackage

// File: rtl/cal_cmd_sync.sv
module cal_cmd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] stg_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cal_cmd_sync: STAGES must be at least 2");
      end
   endgenerate

   // Reset to the idle-high level so reset itself never counts as a low run.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '1;
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cal_cmd_qual.sv
module cal_cmd_qual #(
   parameter int RUN_LEN = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic start_o
);
   localparam int RW = $clog2(RUN_LEN + 1);
   localparam logic [RW-1:0] LEN    = RW'(RUN_LEN);
   localparam logic [RW-1:0] LEN_M1 = RW'(RUN_LEN - 1);

   logic [RW-1:0] lo_q, hi_q;
   logic          armed_q, start_q;

   generate
      if (RUN_LEN < 2) begin : g_bad
         $error("cal_cmd_qual: RUN_LEN must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q    <= '0;
         hi_q    <= '0;
         armed_q <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (!lvl_i) begin
            hi_q    <= '0;
            if (lo_q != LEN) lo_q <= lo_q + 1'b1;
            armed_q <= (lo_q >= LEN_M1);
         end else begin
            lo_q <= '0;
            if (hi_q != LEN) hi_q <= hi_q + 1'b1;
            if (armed_q && (hi_q == LEN_M1)) begin
               start_q <= 1'b1;
               armed_q <= 1'b0;
            end
         end
      end
   end

   assign start_o = start_q;
endmodule

// File: rtl/cal_pwrup_dly.sv
module cal_pwrup_dly #(
   parameter int EXP_SHORT = 24,
   parameter int EXP_LONG  = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_i,
   input  logic sel_i,
   output logic fire_o
);
   localparam int CW = EXP_LONG + 1;
   localparam logic [CW-1:0] LIM_S = (CW'(1) << EXP_SHORT) - CW'(1);
   localparam logic [CW-1:0] LIM_L = (CW'(1) << EXP_LONG) - CW'(1);

   logic [CW-1:0] cnt_q;
   logic          done_q, fire_q;
   logic [CW-1:0] lim;

   generate
      if (EXP_SHORT < 1 || EXP_SHORT >= EXP_LONG || EXP_LONG > 40) begin : g_bad
         $error("cal_pwrup_dly: need 1 <= EXP_SHORT < EXP_LONG <= 40");
      end
   endgenerate

   assign lim = sel_i ? LIM_L : LIM_S;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (!done_q && !hold_i) begin
            if (cnt_q >= lim) begin
               fire_q <= 1'b1;
               done_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign fire_o = fire_q;
endmodule

// File: rtl/cal_run_ctrl.sv
module cal_run_ctrl
   import cal_seq_pkg::*;
#(
   parameter int CAL_CYCLES = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_dn_i,
   input  logic cmd_lvl_i,
   input  logic pu_fire_i,
   input  logic cmd_start_i,
   input  logic done_i,
   input  logic fsr_i,
   output logic busy_o,
   output logic stale_o
);
   logic     busy_q, pend_q, stale_q, fsr_q;
   logic     pu_want, drop_pu, finish, abort, tmr_end;
   cal_src_e src;

   always_comb begin
      pu_want = pend_q || pu_fire_i;
      drop_pu = pu_want && cmd_lvl_i && !busy_q;
      src     = SRC_NONE;
      if (!busy_q && !pwr_dn_i) begin
         if (pu_want && !cmd_lvl_i) src = SRC_POWERUP;
         else if (cmd_start_i)      src = SRC_COMMAND;
      end
      abort  = busy_q && pwr_dn_i;
      finish = busy_q && !pwr_dn_i && (done_i || tmr_end);
   end

   generate
      if (CAL_CYCLES > 0) begin : g_timer
         localparam int TW = $clog2(CAL_CYCLES + 1);
         logic [TW-1:0] tmr_q;
         assign tmr_end = busy_q && (tmr_q == TW'(CAL_CYCLES - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   tmr_q <= '0;
            else if (src != SRC_NONE)     tmr_q <= '0;
            else if (busy_q && !tmr_end)  tmr_q <= tmr_q + 1'b1;
         end
      end else begin : g_ext_only
         assign tmr_end = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         pend_q  <= 1'b0;
         stale_q <= 1'b1;
         fsr_q   <= 1'b0;
      end else begin
         fsr_q <= fsr_i;
         if (abort || finish)        busy_q <= 1'b0;
         else if (src != SRC_NONE)   busy_q <= 1'b1;
         if (src != SRC_NONE || drop_pu) pend_q <= 1'b0;
         else if (pu_fire_i)             pend_q <= 1'b1;
         if ((fsr_i != fsr_q) || abort) stale_q <= 1'b1;
         else if (finish)               stale_q <= 1'b0;
      end
   end

   assign busy_o  = busy_q;
   assign stale_o = stale_q;
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
   parameter int DLY_EXP_SHORT = 24,
   parameter int DLY_EXP_LONG  = 30,
   parameter int RUN_LEN       = 10,
   parameter int SYNC_STAGES   = 2,
   parameter int CAL_CYCLES    = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cal_cmd_i,
   input  logic pwr_dn_i,
   input  logic dly_sel_i,
   input  logic fsr_sel_i,
   input  logic cal_done_i,
   output logic cal_busy_o,
   output logic recal_req_o
);
   logic cmd_lvl, cmd_start, pu_fire;

   cal_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(cal_cmd_i), .q_o(cmd_lvl)
   );

   cal_cmd_qual #(.RUN_LEN(RUN_LEN)) u_qual (
      .clk(clk), .rst_n(rst_n), .lvl_i(cmd_lvl), .start_o(cmd_start)
   );

   cal_pwrup_dly #(.EXP_SHORT(DLY_EXP_SHORT), .EXP_LONG(DLY_EXP_LONG)) u_dly (
      .clk(clk), .rst_n(rst_n), .hold_i(pwr_dn_i), .sel_i(dly_sel_i),
      .fire_o(pu_fire)
   );

   cal_run_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_run (
      .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .cmd_lvl_i(cmd_lvl),
      .pu_fire_i(pu_fire), .cmd_start_i(cmd_start), .done_i(cal_done_i),
      .fsr_i(fsr_sel_i), .busy_o(cal_busy_o), .stale_o(recal_req_o)
   );
endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_dn_i,
   input logic fsr_sel_i,
   input logic cal_done_i,
   input logic cal_busy_o,
   input logic recal_req_o
);
   logic seen_q, fsr_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q     <= 1'b0;
         fsr_prev_q <= 1'b0;
      end else begin
         seen_q     <= 1'b1;
         fsr_prev_q <= fsr_sel_i;
      end
   end

   AST_NO_START_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_busy_o && pwr_dn_i) |=> !cal_busy_o);                       // R8
   AST_PD_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy_o && pwr_dn_i) |=> !cal_busy_o);                        // R9
   AST_ABORT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy_o && pwr_dn_i) |=> recal_req_o);                        // R9
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_busy_o && cal_done_i) |=> !cal_busy_o);                      // R7
   AST_FSR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && (fsr_sel_i != fsr_prev_q)) |=> recal_req_o);           // R10
endmodule

bind cal_sequencer cal_sequencer_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .fsr_sel_i(fsr_sel_i),
   .cal_done_i(cal_done_i), .cal_busy_o(cal_busy_o), .recal_req_o(recal_req_o)
);

// File: tb/cal_sequencer_bench.sv
module cal_sequencer_bench;
   localparam int ES  = 4;
   localparam int EL  = 6;
   localparam int RL  = 10;
   localparam int CC  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cal_cmd = 1'b0, pwr_dn = 1'b0, dly_sel = 1'b0, fsr = 1'b0, done = 1'b0;
   logic busy, stale;
   int   checks = 0, errors = 0;
   bit   ended = 1'b0;

   always #4 clk = ~clk;

   cal_sequencer #(.DLY_EXP_SHORT(ES), .DLY_EXP_LONG(EL), .RUN_LEN(RL),
                   .SYNC_STAGES(2), .CAL_CYCLES(CC)) u_cal_sequencer (
      .clk(clk), .rst_n(rst_n), .cal_cmd_i(cal_cmd), .pwr_dn_i(pwr_dn),
      .dly_sel_i(dly_sel), .fsr_sel_i(fsr), .cal_done_i(done),
      .cal_busy_o(busy), .recal_req_o(stale)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset(input logic sel, input logic cmd, input logic pd);
      rst_n = 1'b0; dly_sel = sel; cal_cmd = cmd; pwr_dn = pd; done = 1'b0;
      step(3);
      rst_n = 1'b1;
   endtask

   task automatic wait_rise(output int n);
      n = 0;
      do begin step(); n++; end while (!busy && n < 2000);
   endtask

   task automatic width(output int w);
      w = 0;
      while (busy && w < 2000) begin w++; step(); end
   endtask

   task automatic no_busy(input string req, input int n);
      int hits = 0;
      for (int i = 0; i < n; i++) begin step(); if (busy) hits++; end
      chk(req, hits, 0);
   endtask

   task automatic cmd_go(output int lat);
      cal_cmd = 1'b0; step(RL + 2);
      cal_cmd = 1'b1; wait_rise(lat);
   endtask

   initial begin
      int n, w;
      // R1 short delay, R10 reset state, R7 full width
      do_reset(1'b0, 1'b0, 1'b0);
      chk("R10 reset busy", busy, 0);
      chk("R10 reset flag", stale, 1);
      wait_rise(n);
      chk("R1 powerup latency", n, (1 << ES) + 1);
      width(w);
      chk("R7 busy width", w, CC);
      chk("R10 flag cleared after run", stale, 0);

      // R5 command latency, single start while held high
      cmd_go(n);
      chk("R5 command latency", n, RL + 3);
      width(w);
      chk("R7 command busy width", w, CC);
      no_busy("R5 no restart while high", 30);

      // R6 short low run, short high run
      cal_cmd = 1'b0; step(RL - 1);
      cal_cmd = 1'b1; no_busy("R6 short low", RL + 5);
      cal_cmd = 1'b0; step(RL + 10);
      cal_cmd = 1'b1; step(RL - 1);
      cal_cmd = 1'b0; no_busy("R6 short high", RL + 10);

      // R7 done input ends early; ignored when idle
      cmd_go(n);
      step(5);
      done = 1'b1; step(); done = 1'b0;
      chk("R7 done ends run", busy, 0);
      chk("R10 done run clears flag", stale, 0);
      done = 1'b1; step(); done = 1'b0;
      no_busy("R7 done idle ignored", 5);
      chk("R7 done idle flag", stale, 0);

      // R9 abort by power-down
      cmd_go(n);
      step(5);
      pwr_dn = 1'b1; step();
      chk("R9 abort drops busy", busy, 0);
      chk("R9 abort sets flag", stale, 1);

      // R8 command during power-down discarded
      cal_cmd = 1'b0; step(RL + 2);
      cal_cmd = 1'b1; no_busy("R8 no start in power-down", RL + 8);
      pwr_dn = 1'b0;
      no_busy("R8 dropped command stays dropped", 25);

      // R11 command qualified during a run ignored
      cmd_go(n);
      cal_cmd = 1'b0; step(RL + 2);
      cal_cmd = 1'b1;
      width(w);
      chk("R11 run not extended", w, CC - RL - 2);
      no_busy("R11 no second run", 30);

      // R10 range change flags stale until next completion
      chk("R10 clean before change", stale, 0);
      fsr = 1'b1; step();
      chk("R10 change sets flag", stale, 1);
      step(10);
      chk("R10 flag sticky", stale, 1);
      cmd_go(n); width(w);
      chk("R10 cleared by run", stale, 0);

      // R3 power-down freezes delay counter
      do_reset(1'b0, 1'b0, 1'b1);
      step(10); pwr_dn = 1'b0;
      wait_rise(n);
      chk("R3 frozen delay", n + 10, (1 << ES) + 1 + 10);
      width(w);

      // R4 held-high CAL withholds power-up run
      do_reset(1'b0, 1'b1, 1'b0);
      no_busy("R4 withheld", (1 << ES) + 10);
      cmd_go(n);
      chk("R4 command after withhold", n, RL + 3);
      width(w);

      // R2 long delay
      do_reset(1'b1, 1'b0, 1'b0);
      wait_rise(n);
      chk("R2 long latency", n, (1 << EL) + 1);

      if (!ended) begin
         ended = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule